// File: doc/BRIEF.md
# Spike Event Arbiter

The block gathers spike requests from a bank of neuron outputs split into independent groups (eight groups of 64 by default). Each group owns a request register and a fixed-priority encoder. When a group holds pending spikes, the encoder picks one. The group then offers that neuron's index on its own output lane as an event with a valid/ready handshake.

Requests are sticky. A spike stays pending until its event has been accepted, so spikes that fire in the same cycle wait their turn and none is lost. Each group can be switched off on its own. A switched-off group drops what it holds and emits nothing. Every lane runs in parallel with the others, so an event on one lane never waits on another lane.

Top module: `spike_event_arbiter`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it is released, every lane's valid is low, and spikes driven during reset are not retained.
- R2: A spike on input bit g*64+i of an enabled, idle group g is sampled at a rising edge. From that edge on, lane g shows valid high with index i.
- R3: When several requests are pending in one group, the lowest input index is presented first.
- R4: A set of spikes arriving together in one group is delivered completely, one event per accepted handshake, in ascending index order.
- R5: A handshake (valid and ready high at an edge) clears only the granted request. The next pending index, or valid low if none remains, appears from that same edge.
- R6: While valid is high and ready is low, the lane keeps valid high and its index unchanged, even if a lower-indexed spike arrives meanwhile.
- R7: A spike on an input in the same cycle that this input's event is accepted is kept as a new pending request, and it is offered again.
- R8: While a group's enable is low, its spike inputs are ignored and its valid is low from the next edge. Requests pending when the group is disabled are discarded, so nothing is offered after it is re-enabled.
- R9: Groups work independently. Lane g's request bits are spike bits [g*64+63 : g*64], and lane g's index field is bits [g*6+5 : g*6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spike_i | input | N_GROUPS*GROUP_W | Spike request per neuron, group-major |
| grp_en_i | input | N_GROUPS | Per-group enable |
| evt_ready_i | input | N_GROUPS | Per-lane acceptance of the offered event |
| evt_valid_o | output | N_GROUPS | Per-lane event valid, registered |
| evt_idx_o | output | N_GROUPS*IDX_W | Per-lane neuron index of the offered event, registered |

## Verification
The hardest situation to create is a fresh spike on exactly the input whose event is being accepted in that same cycle. Here the clear and the set of one request bit meet. The stimulus holds that input high across the handshake edge. It then checks that the same index comes back once more before the lane goes idle. A second hard case is a lower-indexed spike that arrives while the lane is stalled. The bench holds ready low on that lane, injects the lower spike, checks that the offered index does not move, and only then releases ready to watch the lower index follow.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int unsigned SPK_GROUPS_DEF = 8;
  localparam int unsigned SPK_WIDTH_DEF  = 64;
endpackage

// File: rtl/spk_req_latch.sv
module spk_req_latch #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_d_o,
  output logic [W-1:0] pend_q_o
);
  logic [W-1:0] pend_q;

  always_comb begin
    if (!en_i) pend_d_o = '0;
    else       pend_d_o = (pend_q & ~clr_i) | req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;

  AST_REQ_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (($past(req_i) & ~pend_q) == '0));  // R4
  AST_DIS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (pend_q == '0));  // R8
endmodule

// File: rtl/spk_prio_enc.sv
module spk_prio_enc #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] below;

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
  assign below = (W'(1) << idx_o) - W'(1);

  always_comb begin
    if (any_o) begin
      AST_PICK_IS_SET: assert (req_i[idx_o]);  // R2
      AST_LOWEST_WINS: assert ((req_i & below) == '0);  // R3
    end
  end
endmodule

// File: rtl/spk_group.sv
module spk_group #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [W-1:0]  spike_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0]  pend_q, pend_d, clr;
  logic          valid_q, fire, sel_any;
  logic [IW-1:0] idx_q, sel_idx;

  assign fire = valid_q & ready_i;
  assign clr  = fire ? (W'(1) << idx_q) : '0;

  spk_req_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .en_i(en_i), .req_i(spike_i), .clr_i(clr),
    .pend_d_o(pend_d), .pend_q_o(pend_q)
  );

  spk_prio_enc #(.W(W), .IW(IW)) u_enc (
    .req_i(pend_d), .any_o(sel_any), .idx_o(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (!(valid_q && !ready_i)) begin
      valid_q <= sel_any;
      idx_q   <= sel_idx;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && valid_q && !ready_i) |=> (valid_q && $stable(idx_q)));  // R6
  AST_DIS_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !valid_q);  // R8
  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> pend_q[idx_q]);  // R5
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (en_i && fire && !spike_i[idx_q]) |=> !pend_q[$past(idx_q)]);  // R5
  AST_REGRANT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (en_i && fire && spike_i[idx_q]) |=> pend_q[$past(idx_q)]);  // R7
endmodule

// File: rtl/spike_event_arbiter.sv
module spike_event_arbiter #(
  parameter int unsigned N_GROUPS = spk_pkg::SPK_GROUPS_DEF,
  parameter int unsigned GROUP_W  = spk_pkg::SPK_WIDTH_DEF,
  parameter int unsigned IDX_W    = $clog2(GROUP_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_GROUPS*GROUP_W-1:0] spike_i,
  input  logic [N_GROUPS-1:0]         grp_en_i,
  input  logic [N_GROUPS-1:0]         evt_ready_i,
  output logic [N_GROUPS-1:0]         evt_valid_o,
  output logic [N_GROUPS*IDX_W-1:0]   evt_idx_o
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_lane
    spk_group #(.W(GROUP_W), .IW(IDX_W)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .en_i    (grp_en_i[g]),
      .spike_i (spike_i[g*GROUP_W +: GROUP_W]),
      .ready_i (evt_ready_i[g]),
      .valid_o (evt_valid_o[g]),
      .idx_o   (evt_idx_o[g*IDX_W +: IDX_W])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (evt_valid_o == '0));  // R1
endmodule

// File: tb/tb_spike_event_arbiter.sv
module tb_spike_event_arbiter;
  localparam int G  = 8;
  localparam int W  = 64;
  localparam int IW = 6;
  localparam int TBL_N = 6;
  localparam int TBL_GRP [TBL_N] = '{0, 3, 7, 4, 6, 1};
  localparam logic [63:0] TBL_PAT [TBL_N] = '{
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001,
    64'h0000_0000_0000_00F0, 64'hA5A5_0000_A5A5_0000,
    64'h8000_0000_0000_0000, 64'h0101_0000_0010_0204};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [G*W-1:0]  spike = '0;
  logic [G-1:0]    en  = '1;
  logic [G-1:0]    rdy = '1;
  logic [G-1:0]    vld;
  logic [G*IW-1:0] idx;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spike_event_arbiter dut (
    .clk(clk), .rst(rst), .spike_i(spike), .grp_en_i(en),
    .evt_ready_i(rdy), .evt_valid_o(vld), .evt_idx_o(idx)
  );

  function automatic int lane_idx(int g);
    return int'(idx[g*IW +: IW]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    // R1: spikes during reset are not kept
    spike[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk(vld == '0, "R1", int'(vld), 0);
    rst = 1'b0; spike = '0;
    @(negedge clk);
    chk(vld == '0, "R1", int'(vld), 0);

    // Table walk: R3 R4 R5 ascending drain of simultaneous spikes
    for (int t = 0; t < TBL_N; t++) begin
      @(negedge clk);
      spike[TBL_GRP[t]*W +: W] = TBL_PAT[t];
      @(negedge clk);
      spike = '0;
      for (int b = 0; b < W; b++) begin
        if (TBL_PAT[t][b]) begin
          chk(vld[TBL_GRP[t]] && lane_idx(TBL_GRP[t]) == b, "R3 R4",
              lane_idx(TBL_GRP[t]), b);
          @(negedge clk);
        end
      end
      chk(vld[TBL_GRP[t]] == 1'b0, "R5", int'(vld[TBL_GRP[t]]), 0);
    end

    // R2 and R6: stall holds index while a lower spike arrives
    @(negedge clk);
    rdy[2] = 1'b0; spike[2*W+10] = 1'b1;
    @(negedge clk);
    spike = '0; spike[2*W+3] = 1'b1;
    chk(vld[2] && lane_idx(2) == 10, "R2", lane_idx(2), 10);
    @(negedge clk);
    spike = '0;
    chk(vld[2] && lane_idx(2) == 10, "R6", lane_idx(2), 10);
    @(negedge clk);
    chk(vld[2] && lane_idx(2) == 10, "R6", lane_idx(2), 10);
    rdy[2] = 1'b1;
    @(negedge clk);
    chk(vld[2] && lane_idx(2) == 3, "R3 R5", lane_idx(2), 3);
    @(negedge clk);
    chk(vld[2] == 1'b0, "R5", int'(vld[2]), 0);

    // R7: re-request during grant of same input
    spike[5*W+7] = 1'b1;
    @(negedge clk);
    chk(vld[5] && lane_idx(5) == 7, "R2", lane_idx(5), 7);
    @(negedge clk);
    spike = '0;
    chk(vld[5] && lane_idx(5) == 7, "R7", lane_idx(5), 7);
    @(negedge clk);
    chk(vld[5] == 1'b0, "R7", int'(vld[5]), 0);

    // R8: disabled group ignores inputs and drops pending requests
    en[1] = 1'b0; spike[1*W +: W] = '1;
    @(negedge clk);
    chk(vld[1] == 1'b0, "R8", int'(vld[1]), 0);
    spike = '0; en[1] = 1'b1;
    @(negedge clk);
    chk(vld[1] == 1'b0, "R8", int'(vld[1]), 0);
    rdy[1] = 1'b0; spike[1*W+20] = 1'b1;
    @(negedge clk);
    spike = '0;
    chk(vld[1] && lane_idx(1) == 20, "R2", lane_idx(1), 20);
    en[1] = 1'b0;
    @(negedge clk);
    chk(vld[1] == 1'b0, "R8", int'(vld[1]), 0);
    en[1] = 1'b1; rdy[1] = 1'b1;
    @(negedge clk);
    chk(vld[1] == 1'b0, "R8", int'(vld[1]), 0);

    // R9: every lane in parallel with its own index field
    for (int g = 0; g < G; g++) spike[g*W + g*7 + 1] = 1'b1;
    @(negedge clk);
    spike = '0;
    for (int g = 0; g < G; g++)
      chk(vld[g] && lane_idx(g) == g*7 + 1, "R9", lane_idx(g), g*7 + 1);
    @(negedge clk);
    chk(vld == '0, "R9", int'(vld), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule